// File: doc/BRIEF.md
# Edge Event Counter with Snapshot

This block counts transitions on an external event input with a wrapping counter, 16 bits wide by default. The input passes through a synchronizer before edge detection. A configuration bit chooses whether rising or falling transitions are counted.

The host reads the count through a snapshot register. A one-cycle request copies the whole live count into it at once, so both bytes come from the same instant and the count keeps running. While the host holds the preload control high, it can overwrite either byte of the counter, and no events are counted. Events that arrive during that time are discarded, not saved for later.

A low-power polled mode looks at the input only during a short window that repeats every sampling period. The period and window lengths are parameters in system-clock cycles. The polled mode counts rising transitions only, whatever the edge-select bit says, and it samples only while the timing oscillator enable is high.

Top module: `evt_edge_counter`

## Requirements
- R1: After reset, `snap_out` reads 0, `sample_win` is 0, and the live count is 0.
- R2: In continuous mode (`cfg_poll`=0) with `cfg_rise`=1, each 0-to-1 transition of `evt_in` adds one to the count, and 1-to-0 transitions add nothing.
- R3: In continuous mode with `cfg_rise`=0, each 1-to-0 transition of `evt_in` adds one to the count, and 0-to-1 transitions add nothing.
- R4: A one-cycle `snap_req` copies the live count, as it was in that cycle, into `snap_out`. `snap_out` does not change in any cycle without `snap_req`.
- R5: While `wr_hold`=1, a cycle with `wr_en`=1 loads `wr_data` into one counter byte. `wr_sel`=0 selects bits 7:0 and `wr_sel`=1 selects bits 15:8. A `wr_en` while `wr_hold`=0 has no effect.
- R6: While `wr_hold`=1, transitions on `evt_in` are not counted and are not remembered. Counting resumes once `wr_hold` returns to 0.
- R7: The count wraps from FFFFh to 0000h. Outside of writes, it changes by at most one per cycle.
- R8: With `cfg_poll`=1 and `osc_en`=1, `sample_win` is high for WIN_CYC consecutive cycles out of every PERIOD_CYC cycles. `evt_in` is examined only while `sample_win` is high, so a pulse that begins and ends between windows is not counted.
- R9: In polled mode, a transition counts when the input is high in a window and was low at the previous polled sample. This holds even when `cfg_rise`=0. A falling transition is never counted in polled mode.
- R10: With `cfg_poll`=1 and `osc_en`=0, `sample_win` is 0 from the next cycle on, and no transitions are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Asynchronous event input |
| cfg_rise | input | 1 | Edge select: 1 = rising, 0 = falling (continuous mode) |
| cfg_poll | input | 1 | 1 = polled sampling mode |
| osc_en | input | 1 | Timing oscillator enable, required for polled sampling |
| snap_req | input | 1 | One-cycle request to copy the count into the snapshot |
| wr_hold | input | 1 | Preload control: freezes counting and enables byte writes |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | SEL_W | Byte select: 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Byte value to load |
| snap_out | output | CNT_W | Snapshot register, both bytes |
| sample_win | output | 1 | High while the polled window is open |

## Verification
The live count is visible only through the snapshot. A wrong increment, a lost write or a missed freeze therefore shows at the port on the first snapshot after the event. The bench takes that snapshot four cycles after each stimulus, which covers the two synchronizer stages and the counter register. A fault in the window timer shows directly on `sample_win` within one sampling period. A stale polled-sample register shows as an extra or missing count after the next window closes. A snapshot register that drifts between requests is caught by reading `snap_out` again after events arrive with no request.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

    typedef enum logic {
        DET_CONT = 1'b0,
        DET_POLL = 1'b1
    } det_mode_e;

    // True when the pair (prev, cur) forms the selected transition.
    function automatic logic edge_match(input logic cur, input logic prev,
                                        input logic rising);
        return rising ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_out = sh_q[STAGES-1];

endmodule

// File: rtl/evt_poll_timer.sv
module evt_poll_timer #(
    parameter int PERIOD_CYC = 1000,
    parameter int WIN_CYC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic win
);

    localparam int TW = $clog2(PERIOD_CYC + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          win;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.tmr = '0;
            st_d.win = 1'b0;
        end else begin
            if (st_q.tmr == TW'(PERIOD_CYC - 1)) st_d.tmr = '0;
            else                                 st_d.tmr = st_q.tmr + TW'(1);
            st_d.win = (st_d.tmr < TW'(WIN_CYC));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win = st_q.win;

endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det
    import evt_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic polled,
    input  logic win,
    input  logic rise_sel,
    output logic hit
);

    det_mode_e mode;
    logic prev_d, prev_q;

    always_comb begin
        mode   = polled ? DET_POLL : DET_CONT;
        prev_d = prev_q;
        hit    = 1'b0;
        case (mode)
            DET_CONT: begin
                prev_d = level;
                hit    = edge_match(level, prev_q, rise_sel);
            end
            DET_POLL: begin
                // Only window samples refresh the reference; rising forced.
                if (win) begin
                    prev_d = level;
                    hit    = edge_match(level, prev_q, 1'b1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/evt_edge_counter.sv
module evt_edge_counter #(
    parameter int CNT_W       = 16,
    parameter int SEL_W       = 1,
    parameter int SYNC_STAGES = 2,
    parameter int PERIOD_CYC  = 1000,
    parameter int WIN_CYC     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             cfg_rise,
    input  logic             cfg_poll,
    input  logic             osc_en,
    input  logic             snap_req,
    input  logic             wr_hold,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] snap_out,
    output logic             sample_win
);

    localparam int NBYTES = CNT_W / 8;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] snap;
    } state_t;

    state_t st_d, st_q;
    logic   evt_s;
    logic   edge_hit;
    logic   poll_run;
    logic [CNT_W-1:0] count_live;

    assign poll_run = cfg_poll & osc_en;

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (evt_in),
        .q_out (evt_s)
    );

    evt_poll_timer #(.PERIOD_CYC(PERIOD_CYC), .WIN_CYC(WIN_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (poll_run),
        .win   (sample_win)
    );

    evt_edge_det u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (evt_s),
        .polled   (cfg_poll),
        .win      (sample_win),
        .rise_sel (cfg_rise),
        .hit      (edge_hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_hold) begin
            if (wr_en) begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (wr_sel == SEL_W'(b)) st_d.count[b*8 +: 8] = wr_data;
                end
            end
        end else if (edge_hit) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
        if (snap_req) st_d.snap = st_q.count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_out   = st_q.snap;
    assign count_live = st_q.count;

endmodule

// File: rtl/evt_edge_counter_chk.sv
module evt_edge_counter_chk #(
    parameter int CNT_W   = 16,
    parameter int WIN_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_hold,
    input logic             wr_en,
    input logic             snap_req,
    input logic             osc_en,
    input logic             sample_win,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] snap_out
);

    logic [31:0] win_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          win_run_q <= '0;
        else if (sample_win) win_run_q <= win_run_q + 32'd1;
        else                 win_run_q <= '0;
    end

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap_out));

    // R4
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> snap_out == $past(count));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && !wr_en) |=> count == $past(count));

    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hold |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

    // R10
    no_osc_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !sample_win);

    // R8
    win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_win |-> win_run_q < 32'(WIN_CYC));

endmodule

bind evt_edge_counter evt_edge_counter_chk #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hold    (wr_hold),
    .wr_en      (wr_en),
    .snap_req   (snap_req),
    .osc_en     (osc_en),
    .sample_win (sample_win),
    .count      (count_live),
    .snap_out   (snap_out)
);

// File: tb/evt_edge_counter_tb.sv
module evt_edge_counter_tb_top;

    localparam int PER = 40;
    localparam int WIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic        cfg_rise = 1'b1;
    logic        cfg_poll = 1'b0;
    logic        osc_en = 1'b0;
    logic        snap_req = 1'b0;
    logic        wr_hold = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] snap_out;
    logic        sample_win;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    evt_edge_counter #(.CNT_W(16), .SEL_W(1), .SYNC_STAGES(2),
                       .PERIOD_CYC(PER), .WIN_CYC(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_rise(cfg_rise),
        .cfg_poll(cfg_poll), .osc_en(osc_en), .snap_req(snap_req),
        .wr_hold(wr_hold), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .snap_out(snap_out), .sample_win(sample_win)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1; idle(4);
            evt_in = 1'b0; idle(4);
        end
    endtask

    task automatic take_snap;
        @(negedge clk); snap_req = 1'b1;
        @(negedge clk); snap_req = 1'b0;
    endtask

    task automatic write_byte(input logic sel, input logic [7:0] val);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_window_end;
        do @(negedge clk); while (!sample_win);
        do @(negedge clk); while (sample_win);
    endtask

    task automatic t_reset;
        idle(3); rst_n = 1'b1; idle(2);
        check("R1 snapshot", 32'(snap_out), 32'h0);
        check("R1 window", 32'(sample_win), 32'h0);
        take_snap;
        check("R1 count", 32'(snap_out), 32'h0);
    endtask

    task automatic t_rise;
        cfg_rise = 1'b1; pulses(3); take_snap;
        check("R2 rising count", 32'(snap_out), 32'd3);
    endtask

    task automatic t_fall;
        cfg_rise = 1'b0; idle(2); pulses(2); take_snap;
        check("R3 falling count", 32'(snap_out), 32'd5);
    endtask

    task automatic t_snap_hold;
        pulses(2);
        check("R4 snapshot held", 32'(snap_out), 32'd5);
        take_snap;
        check("R4 snapshot refresh", 32'(snap_out), 32'd7);
    endtask

    task automatic t_preload;
        @(negedge clk); wr_hold = 1'b1;
        write_byte(1'b0, 8'h34);
        write_byte(1'b1, 8'h12);
        @(negedge clk); wr_hold = 1'b0;
        take_snap;
        check("R5 preload", 32'(snap_out), 32'h1234);
        write_byte(1'b0, 8'hFF);
        take_snap;
        check("R5 write ignored", 32'(snap_out), 32'h1234);
    endtask

    task automatic t_block;
        @(negedge clk); wr_hold = 1'b1;
        pulses(3);
        @(negedge clk); wr_hold = 1'b0;
        idle(3); take_snap;
        check("R6 blocked", 32'(snap_out), 32'h1234);
        pulses(1); take_snap;
        check("R6 resumed", 32'(snap_out), 32'h1235);
    endtask

    task automatic t_wrap;
        @(negedge clk); wr_hold = 1'b1;
        write_byte(1'b0, 8'hFE);
        write_byte(1'b1, 8'hFF);
        @(negedge clk); wr_hold = 1'b0;
        pulses(3); take_snap;
        check("R7 wrap", 32'(snap_out), 32'h0001);
    endtask

    task automatic t_poll_nosc;
        int seen = 0;
        cfg_poll = 1'b1; osc_en = 1'b0; idle(2);
        evt_in = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sample_win) seen++;
        end
        evt_in = 1'b0; idle(6);
        check("R10 no window", 32'(seen), 32'd0);
        take_snap;
        check("R10 no count", 32'(snap_out), 32'h0001);
    endtask

    task automatic t_poll_win;
        int seen = 0;
        osc_en = 1'b1;
        wait_window_end;
        do @(negedge clk); while (!sample_win);
        for (int i = 0; i < 2 * PER; i++) begin
            if (sample_win) seen++;
            @(negedge clk);
        end
        check("R8 window cycles", 32'(seen), 32'(2 * WIN));
    endtask

    task automatic t_poll_edge;
        cfg_rise = 1'b0;
        wait_window_end;
        evt_in = 1'b1; idle(10); evt_in = 1'b0;
        wait_window_end;
        take_snap;
        check("R8 pulse between windows", 32'(snap_out), 32'h0001);
        evt_in = 1'b1;
        wait_window_end;
        take_snap;
        check("R9 forced rising", 32'(snap_out), 32'h0002);
        evt_in = 1'b0;
        wait_window_end;
        take_snap;
        check("R9 falling ignored", 32'(snap_out), 32'h0002);
        cfg_poll = 1'b0; osc_en = 1'b0; idle(4);
    endtask

    initial begin
        t_reset;
        t_rise;
        t_fall;
        t_snap_hold;
        t_preload;
        t_block;
        t_wrap;
        t_poll_nosc;
        t_poll_win;
        t_poll_edge;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule